// File: doc/BRIEF.md
# Calendar Alarm Comparator with Sticky Interrupt

This unit sits next to a calendar counter and watches its seven time fields (second, minute, hour, weekday, day of month, month, year). Software stores a target time in seven alarm registers and programs a control byte that holds a master enable and one compare enable per field. On every tick strobe from the counter, the unit compares the live time with the target. Each field either takes part in the comparison or, if its enable is clear, counts as matching.

When an enabled alarm matches, a sticky status flag is set. The interrupt request is raised while the flag is set and the alarm is enabled. Software acknowledges the event by writing one to the status bit. Writing zero to the control byte stops the alarm and masks the interrupt in one step.

Access goes through a simple byte-wide register port: a write strobe with address and data, and combinational read data for the presented address.

Top module: `rtc_alarm`

## Requirements
- R1: Seven alarm field registers are read/write storage at byte addresses 0x78 (second), 0x74 (minute), 0x70 (hour), 0x6C (weekday), 0x68 (day of month), 0x64 (month) and 0x60 (year). Each resets to zero.
- R2: The control byte at 0x7C is read/write and resets to zero. Bit 0 is the master alarm enable.
- R3: Writing 0x00 to the control byte stops the alarm, and `irq` is low from the next cycle on.
- R4: Control bits 1 to 7 enable comparison of second, minute, hour, weekday, day of month, month and year, in that order. A field whose bit is 0 always counts as matching.
- R5: The comparison is made only in a cycle where `tick` is high. A matching live time without `tick` does not set the flag.
- R6: The status flag is bit 4 of the byte at 0x30. It is set at the clock edge that ends the first matching tick while bit 0 of the control byte is 1. Once set, it stays set until it is acknowledged.
- R7: Writing a byte with bit 4 = 1 to 0x30 clears the flag. Writing a byte with bit 4 = 0 leaves the flag unchanged.
- R8: If a match and a clear write occur in the same cycle, the flag stays set.
- R9: `irq` is high exactly when the flag is set and bit 0 of the control byte is 1. A match while the alarm is disabled does not set the flag.
- R10: Reads from unmapped addresses return 0. Bits of 0x30 other than bit 4 read as 0.
- R11: `live_time` packs the fields with the second in bits [FIELD_W-1:0], then minute, hour, weekday, day of month and month, with the year in the highest field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Strobe: `live_time` has just been updated and is valid |
| live_time | input | 7*FIELD_W | Current calendar fields, second lowest |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Alarm interrupt request |

## Verification
The assertions run on every cycle and cover the following: the flag is sticky unless it is acknowledged; the flag rises only after a qualified tick match; a match wins over a clear in the same cycle; a fully masked enabled tick always matches; a zero control write drops `irq`; and every field write is stored. Only the bench scenarios show the behaviour that depends on chosen values: the mapping of addresses to fields, which control bit masks which field, and that a disabled or tickless match leaves the flag at zero. They also show the exact read values of the status byte and of unmapped addresses.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6
  } field_e;

  localparam logic [BYTE_W-1:0] ADDR_STATUS    = 8'h30;
  localparam logic [BYTE_W-1:0] ADDR_CTRL      = 8'h7C;
  localparam logic [BYTE_W-1:0] ADDR_FIELD_SEC = 8'h78;
  localparam int                STATUS_BIT     = 4;
  localparam int                CTRL_EN_BIT    = 0;

  // Fields descend in address by 4 bytes from the second down to the year.
  function automatic logic [BYTE_W-1:0] field_addr(input int idx);
    return ADDR_FIELD_SEC - BYTE_W'(4 * idx);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [BYTE_W-1:0]                   addr,
  input  logic [BYTE_W-1:0]                   wdata,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alm_fields,
  output logic [BYTE_W-1:0]                   ctrl
);
  logic [NUM_FIELDS-1:0] fld_sel;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sel
    assign fld_sel[g] = wr_en && (addr == field_addr(g));

    AST_FIELD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      fld_sel[g] |=> alm_fields[g] == $past(wdata[FIELD_W-1:0])); // R1
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_fields <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (fld_sel[i]) alm_fields[i] <= wdata[FIELD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl <= '0;
    else if (wr_en && addr == ADDR_CTRL)  ctrl <= wdata;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic                                alarm_en,
  input  logic [NUM_FIELDS-1:0]               cmp_en,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  live,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  target,
  output logic                                hit_tick
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign fld_ok[g] = !cmp_en[g] || (live[g] == target[g]);
  end

  assign hit_tick = tick && alarm_en && (&fld_ok);

  AST_MASKED_ALWAYS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && alarm_en && cmp_en == '0) |-> hit_tick); // R4
endmodule

// File: rtl/rtc_alarm_status.sv
module rtc_alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_tick,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit_tick) flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit_tick)); // R6
  AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tick && clr_req) |=> flag); // R8
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic [NUM_FIELDS*FIELD_W-1:0]  live_time,
  input  logic                           bus_wr,
  input  logic [BYTE_W-1:0]              bus_addr,
  input  logic [BYTE_W-1:0]              bus_wdata,
  output logic [BYTE_W-1:0]              bus_rdata,
  output logic                           irq
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] live_f;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_f;
  logic [BYTE_W-1:0]                  ctrl;
  logic                               hit_tick;
  logic                               clr_req;
  logic                               flag;
  logic                               alarm_en;

  assign live_f   = live_time;
  assign alarm_en = ctrl[CTRL_EN_BIT];
  assign clr_req  = bus_wr && (bus_addr == ADDR_STATUS) && bus_wdata[STATUS_BIT];

  rtc_alarm_regs #(.FIELD_W(FIELD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .alm_fields (alm_f),
    .ctrl       (ctrl)
  );

  rtc_alarm_match #(.FIELD_W(FIELD_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .alarm_en (alarm_en),
    .cmp_en   (ctrl[NUM_FIELDS:1]),
    .live     (live_f),
    .target   (alm_f),
    .hit_tick (hit_tick)
  );

  rtc_alarm_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_tick (hit_tick),
    .clr_req  (clr_req),
    .flag     (flag)
  );

  assign irq = alarm_en && flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STATUS) begin
      bus_rdata[STATUS_BIT] = flag;
    end else if (bus_addr == ADDR_CTRL) begin
      bus_rdata = ctrl;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (bus_addr == field_addr(i)) bus_rdata[FIELD_W-1:0] = alm_f[i];
      end
    end
  end

  AST_STOP_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTRL && bus_wdata == '0) |=> !irq); // R3
  AST_NO_IRQ_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit_tick) || $past(flag))); // R9
endmodule

// File: tb/rtc_alarm_tb.sv
module rtc_alarm_tb;
  localparam int FW = 8;
  localparam int NF = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [NF*FW-1:0] live_time = '0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rtc_alarm #(.FIELD_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .live_time(live_time),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Field addresses, second first (R1).
  function automatic logic [7:0] faddr(input int i);
    logic [7:0] tbl [7] = '{8'h78, 8'h74, 8'h70, 8'h6C, 8'h68, 8'h64, 8'h60};
    return tbl[i];
  endfunction

  // Pack a time, year first in the argument list, second in the low byte (R11).
  function automatic logic [NF*FW-1:0] mk(input logic [7:0] yr, mo, md, wd, hr, mi, se);
    return {yr, mo, md, wd, hr, mi, se};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_tick(input logic [NF*FW-1:0] t);
    @(negedge clk);
    live_time = t; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_alarm(input logic [NF*FW-1:0] t);
    for (int i = 0; i < NF; i++) wr(faddr(i), t[i*FW +: FW]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < NF; i++) begin
      rd(faddr(i), d); check("R1 field reset", d, 8'h00);
    end
    rd(8'h7C, d); check("R2 ctrl reset", d, 8'h00);
    rd(8'h30, d); check("R6 status reset", d, 8'h00);
    check("R9 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    for (int i = 0; i < NF; i++) wr(faddr(i), 8'h11 * (i + 1));
    for (int i = 0; i < NF; i++) begin
      rd(faddr(i), d); check("R1 field readback", d, 8'h11 * (i + 1));
    end
    wr(8'h7C, 8'hA4);
    rd(8'h7C, d); check("R2 ctrl readback", d, 8'hA4);
    wr(8'h7C, 8'h00);
    rd(8'h44, d); check("R10 unmapped read", d, 8'h00);
    wr(8'h30, 8'hEF);
    rd(8'h30, d); check("R10 status other bits", d, 8'h00);
  endtask

  task automatic t_full_match;
    logic [7:0] d;
    logic [NF*FW-1:0] t = mk(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56);
    set_alarm(t);
    wr(8'h7C, 8'hFF);
    do_tick(mk(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h57));
    rd(8'h30, d); check("R4 second mismatch", d, 8'h00);
    do_tick(mk(8'h25, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56));
    rd(8'h30, d); check("R4 year mismatch", d, 8'h00);
    @(negedge clk); live_time = t;
    @(negedge clk); @(negedge clk);
    rd(8'h30, d); check("R5 no tick no match", d, 8'h00);
    do_tick(t);
    rd(8'h30, d); check("R6 flag on match", d, 8'h10);
    check("R9 irq on match", {7'd0, irq}, 8'h01);
    do_tick(mk(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h57));
    rd(8'h30, d); check("R6 flag sticky", d, 8'h10);
    wr(8'h30, 8'hEF);
    rd(8'h30, d); check("R7 write zero no effect", d, 8'h10);
    wr(8'h30, 8'h10);
    rd(8'h30, d); check("R7 write one clears", d, 8'h00);
    check("R9 irq after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    set_alarm(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30));
    wr(8'h7C, 8'h03);
    do_tick(mk(8'h99, 8'h12, 8'h28, 8'h06, 8'h23, 8'h59, 8'h30));
    rd(8'h30, d); check("R4 only second compared", d, 8'h10);
    wr(8'h30, 8'h10);
    wr(8'h7C, 8'h81);
    do_tick(mk(8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30));
    rd(8'h30, d); check("R4 year compared", d, 8'h00);
    do_tick(mk(8'h01, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09, 8'h09));
    rd(8'h30, d); check("R4 year match others masked", d, 8'h10);
    wr(8'h30, 8'h10);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    logic [NF*FW-1:0] t = mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30);
    wr(8'h7C, 8'hFE);
    do_tick(t);
    rd(8'h30, d); check("R9 disabled no flag", d, 8'h00);
    check("R9 disabled no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_stop;
    logic [7:0] d;
    logic [NF*FW-1:0] t = mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30);
    wr(8'h7C, 8'hFF);
    do_tick(t);
    check("R9 irq before stop", {7'd0, irq}, 8'h01);
    wr(8'h7C, 8'h00);
    check("R3 stop drops irq", {7'd0, irq}, 8'h00);
    rd(8'h30, d); check("R3 stop keeps flag", d, 8'h10);
    wr(8'h30, 8'h10);
  endtask

  task automatic t_race;
    logic [7:0] d;
    logic [NF*FW-1:0] t = mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30);
    wr(8'h7C, 8'hFF);
    @(negedge clk);
    live_time = t; tick = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(8'h30, d); check("R8 match beats clear", d, 8'h10);
    wr(8'h30, 8'h10);
    rd(8'h30, d); check("R7 clear after race", d, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_full_match();
    t_mask();
    t_disabled();
    t_stop();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule